// File: doc/BRIEF.md
# Relative Conditional Branch Resolver

This block settles one conditional branch each time it is offered an instruction. The branch target is relative to the branch's own address. Each offered item carries three things: a 32-bit instruction word, the address that word was fetched from, and the current 2-bit condition code. The block first checks whether the word is the relative conditional branch. It then picks the mask bit that belongs to the condition code. Finally it returns the address execution continues at: either the relative target or the address just past the 4-byte instruction.

The instruction word is split into four fields, from the top bit down:
- an 8-bit primary opcode in bits 31:24;
- a 4-bit condition mask in bits 23:20;
- a 4-bit secondary opcode in bits 19:16;
- a 16-bit signed halfword count in bits 15:0.

The target is formed in three steps. The count is sign-extended, then doubled into a byte offset. That offset is added to the address of the branch itself, not to the sequential address. The outputs are registered, so a result appears one cycle after its input strobe. The resolver sits after decode in a pipeline and feeds the fetch redirect path.

Top module: `brr_resolver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `resValid`, `brTaken`, `brMatch` and `nextAddr` are all zero.
- R2: `resValid` equals the previous cycle's `inValid`. `brTaken`, `brMatch` and `nextAddr` change only in the cycle after `inValid` was high, and they hold their value otherwise.
- R3: `brMatch` is 1 exactly when bits 31:24 of the word equal parameter `OPCODE` (default 8'h5C) and bits 19:16 equal parameter `SUBOP` (default 4'h9).
- R4: When `brMatch` is 0, `brTaken` is 0 and `nextAddr` is the instruction address plus 4, whatever the mask holds.
- R5: Condition code values mean: 0 = equal/zero, 1 = low/minus, 2 = high/plus, 3 = overflow. Mask bit 23 selects code 0, bit 22 selects code 1, bit 21 selects code 2 and bit 20 selects code 3. On a match, the branch is taken exactly when the selected bit is 1.
- R6: Mask value 0 never branches. Mask value 15 branches for every condition code.
- R7: Mask 8 branches only on code 0. Mask 7 branches on codes 1, 2 and 3 and not on code 0.
- R8: When taken, `nextAddr` equals the instruction address plus the sign-extended bits 15:0 shifted left by one.
- R9: When not taken, `nextAddr` equals the instruction address plus 4.
- R10: The extremes of the offset are exact: immediate 16'h7FFF reaches +65534 bytes, 16'h8000 reaches -65536 bytes, and 16'hFFFF lands 2 bytes before the branch.
- R11: All address sums wrap modulo 2^32, both below zero and past the top.
- R12: For an even instruction address, bit 0 of `nextAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The word, address and condition code are valid this cycle |
| instrWord | input | 32 | Instruction word to resolve |
| instrAddr | input | 32 | Byte address of that instruction |
| condCode | input | 2 | Current condition code |
| resValid | output | 1 | Result registers hold a fresh result |
| brTaken | output | 1 | Branch is taken |
| brMatch | output | 1 | Word decoded as the relative conditional branch |
| nextAddr | output | 32 | Address of the next instruction to fetch |

## Verification
The properties assume that inputs are fully defined whenever `inValid` is high. The halfword-alignment property assumes the offered instruction address is even; it makes no claim for odd addresses. The stimulus keeps within these limits:
- every vector uses an even address;
- every input is driven to a known value from time zero, with reset held across the first edges;
- the corner cases that probe wraparound and offset extremes keep their addresses aligned.

// File: rtl/brr_pkg.sv
package brr_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 8;
  localparam int SUB_W   = 4;
  localparam int IMM_W   = 16;
  localparam int CC_W    = 2;
  localparam int MASK_W  = 1 << CC_W;

  localparam int IMM_LO  = 0;
  localparam int SUB_LO  = IMM_LO + IMM_W;
  localparam int MASK_LO = SUB_LO + SUB_W;
  localparam int OPC_LO  = MASK_LO + MASK_W;

  typedef struct packed {
    logic load;
    logic hit;
    logic go;
  } brr_strobe_t;

endpackage

// File: rtl/brr_ctrl.sv
module brr_ctrl
  import brr_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPCODE = 8'h5C,
  parameter logic [SUB_W-1:0] SUBOP  = 4'h9
) (
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opcField,
  input  logic [SUB_W-1:0]  subField,
  input  logic [MASK_W-1:0] maskField,
  input  logic [CC_W-1:0]   condCode,
  output brr_strobe_t       strobes
);

  logic              isHit;
  logic [MASK_W-1:0] ccSelect;
  logic              condMet;

  assign isHit = (opcField == OPCODE) && (subField == SUBOP);

  // The most significant mask bit belongs to condition code 0.
  for (genvar i = 0; i < MASK_W; i++) begin : g_sel
    assign ccSelect[i] = (condCode == CC_W'(MASK_W - 1 - i));
  end

  assign condMet = |(ccSelect & maskField);

  always_comb begin
    strobes.load = inValid;
    strobes.hit  = isHit;
    strobes.go   = isHit && condMet;
  end

endmodule

// File: rtl/brr_datapath.sv
module brr_datapath
  import brr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  brr_strobe_t       strobes,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [IMM_W-1:0]  immField,
  output logic              resValid,
  output logic              brTaken,
  output logic              brMatch,
  output logic [ADDR_W-1:0] nextAddr
);

  localparam int EXT_W = ADDR_W - IMM_W - 1;

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] byteOffset;
  logic [ADDR_W-1:0] tgtAddr;

  assign seqAddr    = instrAddr + ADDR_W'(INSTR_BYTES);
  assign byteOffset = {{EXT_W{immField[IMM_W-1]}}, immField, 1'b0};
  assign tgtAddr    = instrAddr + byteOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      brTaken  <= 1'b0;
      brMatch  <= 1'b0;
      nextAddr <= '0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) begin
        brTaken  <= strobes.go;
        brMatch  <= strobes.hit;
        nextAddr <= strobes.go ? tgtAddr : seqAddr;
      end
    end
  end

endmodule

// File: rtl/brr_resolver.sv
module brr_resolver
  import brr_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               INSTR_BYTES = 4,
  parameter logic [OPC_W-1:0] OPCODE      = 8'h5C,
  parameter logic [SUB_W-1:0] SUBOP       = 4'h9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  instrAddr,
  input  logic [CC_W-1:0]    condCode,
  output logic               resValid,
  output logic               brTaken,
  output logic               brMatch,
  output logic [ADDR_W-1:0]  nextAddr
);

  brr_strobe_t strobes;

  brr_ctrl #(
    .OPCODE(OPCODE),
    .SUBOP (SUBOP)
  ) u_ctrl (
    .inValid  (inValid),
    .opcField (instrWord[OPC_LO  +: OPC_W]),
    .subField (instrWord[SUB_LO  +: SUB_W]),
    .maskField(instrWord[MASK_LO +: MASK_W]),
    .condCode (condCode),
    .strobes  (strobes)
  );

  brr_datapath #(
    .ADDR_W     (ADDR_W),
    .INSTR_BYTES(INSTR_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .instrAddr(instrAddr),
    .immField (instrWord[IMM_LO +: IMM_W]),
    .resValid (resValid),
    .brTaken  (brTaken),
    .brMatch  (brMatch),
    .nextAddr (nextAddr)
  );

endmodule

// File: rtl/brr_checker.sv
module brr_checker
  import brr_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               INSTR_BYTES = 4,
  parameter logic [OPC_W-1:0] OPCODE      = 8'h5C,
  parameter logic [SUB_W-1:0] SUBOP       = 4'h9
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic [ADDR_W-1:0]  instrAddr,
  input logic [CC_W-1:0]    condCode,
  input logic               resValid,
  input logic               brTaken,
  input logic               brMatch,
  input logic [ADDR_W-1:0]  nextAddr
);

  logic [OPC_W-1:0]  opc;
  logic [SUB_W-1:0]  sub;
  logic [MASK_W-1:0] msk;
  logic [ADDR_W-1:0] off;
  logic              isEq;

  assign opc  = instrWord[OPC_LO +: OPC_W];
  assign sub  = instrWord[SUB_LO +: SUB_W];
  assign msk  = instrWord[MASK_LO +: MASK_W];
  assign off  = {{(ADDR_W-IMM_W-1){instrWord[IMM_LO+IMM_W-1]}}, instrWord[IMM_LO +: IMM_W], 1'b0};
  assign isEq = (condCode == '0);

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> (!resValid && !brTaken && !brMatch)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) inValid |=> resValid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !resValid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> ($stable(nextAddr) && $stable(brTaken))); // R2
  AST_DECODE: assert property (@(posedge clk) disable iff (!rstN) inValid |=> (brMatch == ($past(opc) == OPCODE && $past(sub) == SUBOP))); // R3
  AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN) (resValid && !brMatch) |-> !brTaken); // R4
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN) (inValid && msk == '0) |=> !brTaken); // R6
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rstN) (inValid && msk == '1 && opc == OPCODE && sub == SUBOP) |=> brTaken); // R6
  AST_MASK_EQ_ONLY: assert property (@(posedge clk) disable iff (!rstN) (inValid && msk == 4'h8 && !isEq) |=> !brTaken); // R7
  AST_TARGET: assert property (@(posedge clk) disable iff (!rstN) inValid |=> (!brTaken || nextAddr == $past(instrAddr) + $past(off))); // R8
  AST_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN) inValid |=> (brTaken || nextAddr == $past(instrAddr) + ADDR_W'(INSTR_BYTES))); // R9
  AST_HALFWORD: assert property (@(posedge clk) disable iff (!rstN) (inValid && !instrAddr[0]) |=> !nextAddr[0]); // R12

endmodule

bind brr_resolver brr_checker #(
  .ADDR_W     (ADDR_W),
  .INSTR_BYTES(INSTR_BYTES),
  .OPCODE     (OPCODE),
  .SUBOP      (SUBOP)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .instrWord(instrWord),
  .instrAddr(instrAddr),
  .condCode (condCode),
  .resValid (resValid),
  .brTaken  (brTaken),
  .brMatch  (brMatch),
  .nextAddr (nextAddr)
);

// File: tb/tb_brr_resolver.sv
`timescale 1ns/1ps
module tb_brr_resolver;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] instrAddr = '0;
  logic [1:0]  condCode = '0;
  logic        resValid, brTaken, brMatch;
  logic [31:0] nextAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brr_resolver dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .instrAddr(instrAddr), .condCode(condCode), .resValid(resValid),
    .brTaken(brTaken), .brMatch(brMatch), .nextAddr(nextAddr)
  );

  // {word, addr, cc, expTaken, expMatch, expNext}
  localparam int NV = 14;
  localparam logic [99:0] VEC [NV] = '{
    {32'h5C89_0010, 32'h0000_1000, 2'd0, 1'b1, 1'b1, 32'h0000_1020}, // R7 mask 8 on equal
    {32'h5C89_0010, 32'h0000_1000, 2'd1, 1'b0, 1'b1, 32'h0000_1004}, // R7 mask 8 on low
    {32'h5C79_0010, 32'h0000_1000, 2'd0, 1'b0, 1'b1, 32'h0000_1004}, // R7 mask 7 on equal
    {32'h5C79_0010, 32'h0000_1000, 2'd3, 1'b1, 1'b1, 32'h0000_1020}, // R7 mask 7 on overflow
    {32'h5C09_0010, 32'h0000_1000, 2'd2, 1'b0, 1'b1, 32'h0000_1004}, // R6 mask 0
    {32'h5CF9_FFFF, 32'h0000_2000, 2'd1, 1'b1, 1'b1, 32'h0000_1FFE}, // R10 minus one halfword
    {32'h5C49_7FFF, 32'h0010_0000, 2'd1, 1'b1, 1'b1, 32'h0010_FFFE}, // R10 max forward, R5
    {32'h5C29_8000, 32'h0010_0000, 2'd2, 1'b1, 1'b1, 32'h000F_0000}, // R10 max backward, R5
    {32'h5C19_8000, 32'h0000_0100, 2'd3, 1'b1, 1'b1, 32'hFFFF_0100}, // R11 wrap below zero
    {32'h5C19_0004, 32'hFFFF_FFFC, 2'd3, 1'b1, 1'b1, 32'h0000_0004}, // R11 wrap past top
    {32'h5C19_0004, 32'hFFFF_FFFC, 2'd0, 1'b0, 1'b1, 32'h0000_0000}, // R11 sequential wrap, R9
    {32'h5DF9_0010, 32'h0000_3000, 2'd0, 1'b0, 1'b0, 32'h0000_3004}, // R4 opcode mismatch
    {32'h5CF8_0010, 32'h0000_3000, 2'd2, 1'b0, 1'b0, 32'h0000_3004}, // R4 secondary mismatch
    {32'h5C29_0010, 32'h0000_1000, 2'd1, 1'b0, 1'b1, 32'h0000_1004}  // R5 other bit, R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [31:0] w, input logic [31:0] a, input logic [1:0] c);
    @(negedge clk);
    inValid = 1'b1; instrWord = w; instrAddr = a; condCode = c;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 resValid", 32'(resValid), 0);
    check("R1 brTaken", 32'(brTaken), 0);
    check("R1 nextAddr", nextAddr, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      offer(VEC[i][99:68], VEC[i][67:36], VEC[i][35:34]);
      check("R2 resValid", 32'(resValid), 1);
      check("R3 brMatch", 32'(brMatch), 32'(VEC[i][32]));
      check("R5 brTaken", 32'(brTaken), 32'(VEC[i][33]));
      check("R8 nextAddr", nextAddr, VEC[i][31:0]);
      check("R12 nextAddr bit0", 32'(nextAddr[0]), 0);
    end

    // R6 mask 15 taken for every condition code
    for (int c = 0; c < 4; c++) begin
      offer(32'h5CF9_0002, 32'h0000_4000, 2'(c));
      check("R6 mask15 taken", 32'(brTaken), 1);
      check("R8 mask15 target", nextAddr, 32'h0000_4004);
    end

    // R2 idle cycles: outputs hold, valid drops
    offer(32'h5C89_0040, 32'h0000_5000, 2'd0);
    instrWord = 32'h5C19_0000; instrAddr = 32'h0000_6000; condCode = 2'd3;
    @(negedge clk);
    check("R2 valid drops", 32'(resValid), 0);
    check("R2 hold taken", 32'(brTaken), 1);
    check("R2 hold nextAddr", nextAddr, 32'h0000_5080);

    // R1 reset mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset taken", 32'(brTaken), 0);
    check("R1 reset valid", 32'(resValid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule